// File: doc/BRIEF.md
# Instruction-class scenario sequencer

This block is the control core of a small processor. When the outer pipeline pulses `go`, the block captures a 3-bit instruction-class code. It then drives four operational units through their own four-phase request/acknowledge links: a program-counter incrementer, an instruction fetcher, an ALU and a memory port. Every class has a fixed partial order of unit activations. Activations with no ordering between them are requested in the same cycle and run concurrently. An activation that has a predecessor waits until that predecessor's acknowledge has returned low.

Three classes are conditional. Their first ALU operation is a comparison, and its less-than result `lt` chooses which later activations take place. The block samples `lt` once, when that comparison's handshake completes. When every activation of the class has finished, `done` pulses for one cycle and the block becomes idle again.

Internally, each class is described as up to six activation slots. Each slot names a unit, a set of predecessor slots and a guard (always, only if less-than, only if not less-than). A slot whose guard is false completes without issuing anything, so later activations can depend on it freely.

Top module: `scenario_seq`

## Requirements
- R1: `opcode` is captured on a cycle where `go` is high and the block is idle. A `go` pulse while a class is running is ignored, and the running class finishes unchanged.
- R2: Every unit link is four-phase. A request stays high until its acknowledge is seen high. It then falls, and it does not rise again while that acknowledge is still high.
- R3: An activation is requested only after the acknowledge of each of its predecessors has returned low.
- R4: Activations that do not depend on each other are requested in the same cycle. This applies to the ALU and the first PC increment in class 000, memory and PC increment in class 100, and the ALU and the second PC increment in class 110.
- R5: Unconditional classes. Unit codes: PC=0, fetch=1, ALU=2, memory=3.
  - 000: ALU in parallel with the chain PC then fetch.
  - 110: PC, fetch, then ALU and PC together, then fetch.
  - 101: ALU then fetch.
  - 010: PC, fetch, ALU, fetch.
  - 100: memory in parallel with the chain PC then fetch.
- R6: Conditional classes.
  - 001: compare in parallel with PC then fetch, plus a second ALU after the compare only when less-than holds.
  - 111: compare and PC together. If less-than: fetch, then ALU and PC together, then fetch. Otherwise: PC, then fetch.
  - 011: compare and PC together. If less-than: fetch, ALU, fetch. Otherwise: PC, then fetch.
- R7: `lt` is sampled in the cycle in which the compare's acknowledge is first seen low. Later changes of `lt` have no effect on the branch taken.
- R8: `done` is high for exactly one cycle, one cycle after the last activation has completed. No request is high while `done` is high or while the block is idle.
- R9: No unit ever has two activations outstanding at once.
- R10: During and after reset all requests and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a class (taken only when idle) |
| opcode | input | 3 | Instruction-class code |
| lt | input | 1 | Less-than result of the compare |
| pc_req | output | 1 | PC-increment request |
| pc_ack | input | 1 | PC-increment acknowledge |
| fetch_req | output | 1 | Fetch request |
| fetch_ack | input | 1 | Fetch acknowledge |
| alu_req | output | 1 | ALU request |
| alu_ack | input | 1 | ALU acknowledge |
| mem_req | output | 1 | Memory-access request |
| mem_ack | input | 1 | Memory-access acknowledge |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle. An ALU activation and a PC increment can both start, and the capture of `lt` can coincide with the completion of the compare that later activations depend on.

The bench runs every class with both `lt` values under three patterns of acknowledge latency. For the independent pairs it requires identical request-rise cycles, whatever the latencies. It judges every ordering edge by comparing the rise cycle of the successor with the cycle in which the predecessor's acknowledge fell.

It flips `lt` one cycle after the compare's acknowledge falls. It then judges by the activation counts that the branch follows the value held at completion.

// File: rtl/scenario_seq.sv
module scenario_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [2:0] opcode,
  input  logic       lt,
  output logic       pc_req,
  input  logic       pc_ack,
  output logic       fetch_req,
  input  logic       fetch_ack,
  output logic       alu_req,
  input  logic       alu_ack,
  output logic       mem_req,
  input  logic       mem_ack,
  output logic       done
);
  localparam int NS = 6;
  localparam int NU = 4;
  localparam logic [1:0] U_PC = 2'd0, U_FE = 2'd1, U_AL = 2'd2, U_ME = 2'd3;
  localparam logic [1:0] C_ALL = 2'd0, C_LT = 2'd1, C_GE = 2'd2;

  typedef enum logic [1:0] {S_WAIT, S_REQ, S_REL, S_FIN} slot_st_t;
  typedef struct packed {
    logic       used;
    logic [1:0] unit;
    logic [NS-1:0] deps;
    logic [1:0] cond;
  } slot_cfg_t;

  function automatic slot_cfg_t mk(logic [1:0] u, logic [NS-1:0] d, logic [1:0] c);
    slot_cfg_t r;
    r.used = 1'b1; r.unit = u; r.deps = d; r.cond = c;
    return r;
  endfunction

  function automatic slot_cfg_t decode(logic [2:0] op, int s);
    slot_cfg_t r;
    r = '0;
    case (op)
      3'b000: case (s)
        0: r = mk(U_AL, 6'b000000, C_ALL);
        1: r = mk(U_PC, 6'b000000, C_ALL);
        2: r = mk(U_FE, 6'b000010, C_ALL);
        default: r = '0;
      endcase
      3'b110: case (s)
        0: r = mk(U_PC, 6'b000000, C_ALL);
        1: r = mk(U_FE, 6'b000001, C_ALL);
        2: r = mk(U_AL, 6'b000010, C_ALL);
        3: r = mk(U_PC, 6'b000010, C_ALL);
        4: r = mk(U_FE, 6'b001100, C_ALL);
        default: r = '0;
      endcase
      3'b101: case (s)
        0: r = mk(U_AL, 6'b000000, C_ALL);
        1: r = mk(U_FE, 6'b000001, C_ALL);
        default: r = '0;
      endcase
      3'b010: case (s)
        0: r = mk(U_PC, 6'b000000, C_ALL);
        1: r = mk(U_FE, 6'b000001, C_ALL);
        2: r = mk(U_AL, 6'b000010, C_ALL);
        3: r = mk(U_FE, 6'b000100, C_ALL);
        default: r = '0;
      endcase
      3'b100: case (s)
        0: r = mk(U_ME, 6'b000000, C_ALL);
        1: r = mk(U_PC, 6'b000000, C_ALL);
        2: r = mk(U_FE, 6'b000010, C_ALL);
        default: r = '0;
      endcase
      3'b001: case (s)
        0: r = mk(U_AL, 6'b000000, C_ALL);
        1: r = mk(U_PC, 6'b000000, C_ALL);
        2: r = mk(U_FE, 6'b000010, C_ALL);
        3: r = mk(U_AL, 6'b000001, C_LT);
        default: r = '0;
      endcase
      3'b111: case (s)
        0: r = mk(U_AL, 6'b000000, C_ALL);
        1: r = mk(U_PC, 6'b000000, C_ALL);
        2: r = mk(U_FE, 6'b000011, C_LT);
        3: r = mk(U_AL, 6'b000100, C_LT);
        4: r = mk(U_PC, 6'b000111, C_ALL);
        5: r = mk(U_FE, 6'b011000, C_ALL);
        default: r = '0;
      endcase
      default: case (s)
        0: r = mk(U_AL, 6'b000000, C_ALL);
        1: r = mk(U_PC, 6'b000000, C_ALL);
        2: r = mk(U_FE, 6'b000011, C_LT);
        3: r = mk(U_AL, 6'b000100, C_LT);
        4: r = mk(U_PC, 6'b000011, C_GE);
        5: r = mk(U_FE, 6'b011000, C_ALL);
        default: r = '0;
      endcase
    endcase
    return r;
  endfunction

  logic          running;
  logic [2:0]    op_q;
  logic          lt_q;
  slot_st_t      st [NS];
  slot_cfg_t     cfg [NS];
  logic [NS-1:0] fin;
  logic [NU-1:0] ackv, reqv;
  logic [NS-1:0] busy_m [NU];

  assign ackv = {mem_ack, alu_ack, fetch_ack, pc_ack};

  always_comb begin
    reqv = '0;
    for (int u = 0; u < NU; u++) busy_m[u] = '0;
    for (int s = 0; s < NS; s++) begin
      cfg[s] = decode(op_q, s);
      fin[s] = (st[s] == S_FIN);
      if (st[s] == S_REQ) reqv[cfg[s].unit] = 1'b1;
      if (st[s] == S_REQ || st[s] == S_REL) busy_m[cfg[s].unit][s] = 1'b1;
    end
  end

  assign pc_req    = reqv[0];
  assign fetch_req = reqv[1];
  assign alu_req   = reqv[2];
  assign mem_req   = reqv[3];

  function automatic logic guard_ok(logic [1:0] c, logic l);
    return (c == C_ALL) || (c == C_LT && l) || (c == C_GE && !l);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      op_q    <= '0;
      lt_q    <= 1'b0;
      for (int s = 0; s < NS; s++) st[s] <= S_FIN;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (go) begin
          running <= 1'b1;
          op_q    <= opcode;
          for (int s = 0; s < NS; s++)
            st[s] <= decode(opcode, s).used ? S_WAIT : S_FIN;
        end
      end else if (&fin) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        if (st[0] == S_REL && !ackv[cfg[0].unit]) lt_q <= lt;
        for (int s = 0; s < NS; s++) begin
          case (st[s])
            S_WAIT: if ((cfg[s].deps & ~fin) == '0)
                      st[s] <= guard_ok(cfg[s].cond, lt_q) ? S_REQ : S_FIN;
            S_REQ:  if (ackv[cfg[s].unit])  st[s] <= S_REL;
            S_REL:  if (!ackv[cfg[s].unit]) st[s] <= S_FIN;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_link
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reqv[u] && !ackv[u] |=> reqv[u]);
    assert_no_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reqv[u] && ackv[u] |=> !reqv[u]);
    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy_m[u]) <= 1);
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_quiet_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reqv == '0);
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> reqv == '0);
  assert_class_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(op_q));
endmodule

// File: tb/sim_scenario_seq.sv
`timescale 1ns/1ps
module sim_scenario_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, go = 1'b0, lt = 1'b0;
  logic [2:0] opcode = '0;
  logic [3:0] ackv = '0;
  logic pc_req, fetch_req, alu_req, mem_req, done;
  wire  [3:0] reqv = {mem_req, alu_req, fetch_req, pc_req};

  scenario_seq u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode), .lt(lt),
    .pc_req(pc_req), .pc_ack(ackv[0]), .fetch_req(fetch_req), .fetch_ack(ackv[1]),
    .alu_req(alu_req), .alu_ack(ackv[2]), .mem_req(mem_req), .mem_ack(ackv[3]),
    .done(done));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vec = 0, bad = 0;
  int dly_hi [4], dly_lo [4], cnt [4];
  int rise [4][4], fall [4][4];
  logic want_lt = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic serve(input int u);
    int k;
    forever begin
      @(negedge clk);
      if (reqv[u] && !ackv[u]) begin
        k = cnt[u];
        if (k < 4) rise[u][k] = cyc;
        repeat (dly_hi[u]) @(negedge clk);
        chk(reqv[u], "R2", $sformatf("unit %0d request held until ack", u), int'(reqv[u]), 1);
        ackv[u] = 1'b1;
        do @(negedge clk); while (reqv[u]);
        repeat (dly_lo[u]) @(negedge clk);
        chk(!reqv[u], "R2", $sformatf("unit %0d no re-request while ack high", u), int'(reqv[u]), 0);
        ackv[u] = 1'b0;
        if (k < 4) fall[u][k] = cyc;
        cnt[u] = k + 1;
        if (u == 2 && k == 0) begin
          @(negedge clk);
          lt = ~want_lt;
        end
      end
    end
  endtask

  initial fork
    serve(0); serve(1); serve(2); serve(3);
  join_none

  function automatic int exp_cnt(input logic [2:0] op, input logic l, input int u);
    int t [4];
    case (op)
      3'b000: t = '{1, 1, 1, 0};
      3'b110: t = '{2, 2, 1, 0};
      3'b101: t = '{0, 1, 1, 0};
      3'b010: t = '{1, 2, 1, 0};
      3'b100: t = '{1, 1, 0, 1};
      3'b001: t = l ? '{1, 1, 2, 0} : '{1, 1, 1, 0};
      3'b111: t = l ? '{2, 2, 2, 0} : '{2, 1, 1, 0};
      default: t = l ? '{1, 2, 2, 0} : '{2, 1, 1, 0};
    endcase
    return t[u];
  endfunction

  task automatic order(input int pu, input int pk, input int su, input int sk);
    chk(fall[pu][pk] >= 0 && rise[su][sk] > fall[pu][pk], "R3",
        $sformatf("unit %0d#%0d requested after unit %0d#%0d ack low (rise cycle vs fall cycle)", su, sk, pu, pk),
        rise[su][sk], fall[pu][pk] + 1);
  endtask

  task automatic run_case(input logic [2:0] op, input logic l, input int pat);
    int t;
    string tag;
    bit cond;
    cond = (op == 3'b001 || op == 3'b111 || op == 3'b011);
    tag = cond ? "R6" : "R5";
    for (int u = 0; u < 4; u++) begin
      cnt[u] = 0;
      for (int k = 0; k < 4; k++) begin rise[u][k] = -1; fall[u][k] = -1; end
      case (pat)
        0: begin dly_hi[u] = 1; dly_lo[u] = 1; end
        1: begin dly_hi[u] = (u * 3 + 1) % 5; dly_lo[u] = (u * 2) % 3; end
        default: begin dly_hi[u] = (4 - u) % 4; dly_lo[u] = (u + 2) % 4; end
      endcase
    end
    want_lt = l;
    lt = l;
    @(negedge clk); opcode = op; go = 1'b1;
    @(negedge clk); go = 1'b0; opcode = ~op;
    if (pat == 2) begin
      @(negedge clk); go = 1'b1; opcode = op ^ 3'b101;
      @(negedge clk); go = 1'b0;
    end
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    chk(done, "R8", $sformatf("done seen for class %0d", op), int'(done), 1);
    chk(reqv == 4'b0, "R8", "no request while done", int'(reqv), 0);
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", int'(done), 0);
    for (int u = 0; u < 4; u++)
      chk(cnt[u] == exp_cnt(op, l, u), pat == 2 ? "R1" : tag,
          $sformatf("class %0d lt %0d unit %0d activations", op, l, u), cnt[u], exp_cnt(op, l, u));
    if (cond)
      chk(cnt[2] + cnt[1] == exp_cnt(op, l, 2) + exp_cnt(op, l, 1), "R7",
          $sformatf("branch follows lt at compare completion, class %0d", op),
          cnt[2] + cnt[1], exp_cnt(op, l, 2) + exp_cnt(op, l, 1));
    for (int u = 0; u < 4; u++)
      if (cnt[u] >= 2)
        chk(rise[u][1] > fall[u][0], "R9", $sformatf("unit %0d single outstanding", u), rise[u][1], fall[u][0] + 1);
    case (op)
      3'b000: begin order(0,0,1,0); chk(rise[2][0] == rise[0][0], "R4", "ALU with PC", rise[2][0], rise[0][0]); end
      3'b110: begin order(0,0,1,0); order(1,0,2,0); order(1,0,0,1); order(2,0,1,1); order(0,1,1,1);
                    chk(rise[2][0] == rise[0][1], "R4", "ALU with second PC", rise[2][0], rise[0][1]); end
      3'b101: order(2,0,1,0);
      3'b010: begin order(0,0,1,0); order(1,0,2,0); order(2,0,1,1); end
      3'b100: begin order(0,0,1,0); chk(rise[3][0] == rise[0][0], "R4", "memory with PC", rise[3][0], rise[0][0]); end
      3'b001: begin order(0,0,1,0); if (l) order(2,0,2,1); end
      3'b111: if (l) begin order(2,0,1,0); order(0,0,1,0); order(1,0,2,1); order(1,0,0,1); order(2,1,1,1); order(0,1,1,1); end
              else begin order(2,0,0,1); order(0,0,0,1); order(0,1,1,0); end
      default: if (l) begin order(2,0,1,0); order(0,0,1,0); order(1,0,2,1); order(2,1,1,1); end
               else begin order(2,0,0,1); order(0,0,0,1); order(0,1,1,0); end
    endcase
    repeat (3) @(negedge clk);
    chk(reqv == 4'b0, "R8", "idle after done", int'(reqv), 0);
  endtask

  initial begin
    wait (cyc >= 150000);
    bad++;
    $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, 150000);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int u = 0; u < 4; u++) begin dly_hi[u] = 1; dly_lo[u] = 1; cnt[u] = 0; end
    go = 1'b1;
    repeat (4) @(negedge clk);
    chk(reqv == 4'b0, "R10", "requests low in reset", int'(reqv), 0);
    chk(!done, "R10", "done low in reset", int'(done), 0);
    go = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqv == 4'b0 && !done, "R10", "quiet after reset", int'(reqv), 0);
    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 8; o++)
        for (int l = 0; l < 2; l++)
          run_case(3'(o), 1'(l), p);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule